// File: doc/BRIEF.md
# Twin Integer Butterfly Rounding Multiplier

This block performs one step of an integer DCT or FFT butterfly. A request carries two signed operands `a` and `b`, a signed coefficient `c` and a shift amount `n`. The block forms `a + b` and `a - b` from the same inputs and multiplies each by `c`. It then applies a round-half-up arithmetic right shift by `n` to each product. Both results come back together in one response: the sum path on the primary output and the difference path on the secondary output.

Requests and responses use valid/ready handshakes. The datapath has two register stages: the first adds, subtracts and multiplies, and the second rounds and shifts. A request marked with the reserved flag returns a response with the illegal flag set, and the result outputs keep their previous values.

A two-coefficient butterfly is built from two calls: the second call swaps the operands and uses another coefficient, and the caller accumulates the two results.

Top module: `twin_bfly_rnd`

## Requirements
- R1: The primary result equals rnd(((a + b) mod 2^XLEN) * c mod 2^XLEN, n), where rnd is defined in R4.
- R2: The secondary result equals rnd(((a - b) mod 2^XLEN) * c mod 2^XLEN, n), computed from the same request as R1.
- R3: Sums, differences and products wrap modulo 2^XLEN with no saturation. Only the low XLEN bits of each product are kept, so the most-negative operands and c = 0 follow plain two's-complement arithmetic.
- R4: rnd(p, n) sign-extends the XLEN-bit product p to XLEN+1 bits, adds 2^(n-1), shifts right arithmetically by n and keeps the low XLEN bits. Exact halves therefore round toward positive infinity, and the added constant cannot overflow.
- R5: When n = 0, no constant is added and the product appears unchanged on the output.
- R6: n is an unsigned 5-bit field, and every value from 0 to 31 is honoured.
- R7: A request accepted at a clock edge has its response valid after the second following edge, provided the response side is ready.
- R8: A request with the reserved flag set to 1 produces a response with the illegal flag at 1. The primary and secondary outputs keep the values of the previous legal response (0 after reset). A legal request produces a response with the illegal flag at 0.
- R9: While a response is valid and not accepted, the response outputs and the illegal flag hold stable and request ready is low.
- R10: After reset, response valid, both results and the illegal flag are 0.
- R11: While response ready is held high, request ready stays high and one request is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| a_i | input | XLEN | Operand a, signed |
| b_i | input | XLEN | Operand b, signed |
| c_i | input | XLEN | Coefficient, signed |
| n_i | input | 5 | Right shift amount |
| rsv_i | input | 1 | Reserved-form flag; 1 marks the operation illegal |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted when high together with valid |
| res_sum_o | output | XLEN | Rounded (a+b)*c result, primary |
| res_dif_o | output | XLEN | Rounded (a-b)*c result, secondary |
| illegal_o | output | 1 | Response belongs to a reserved-form request |

## Verification
The bench targets exact halves with both signs, the widest positive product at n = 1, n = 0 and n = 31, the most-negative operands and a zero coefficient. A design that truncated instead of rounding, rounded halves away from zero, let the rounding constant overflow or added a constant at n = 0 would give results that are off by one or have the wrong sign in these cases. It also drives reserved requests between legal ones. A design that overwrote the results, or left the illegal flag set on the next response, would show stale or changed values. Random backpressure covers responses that are dropped, duplicated or changed during a stall.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned SHW = 5;

  typedef struct packed {
    logic             vld;
    logic             ill;
    logic [SHW-1:0]   sh;
  } stage_ctl_t;
endpackage

// File: rtl/bfly_prod_stage.sv
module bfly_prod_stage #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] c_i,
  output logic [XLEN-1:0] p_sum_o,
  output logic [XLEN-1:0] p_dif_o
);
  localparam int unsigned NPATH = 2;

  logic [NPATH-1:0][XLEN-1:0] op;
  logic [NPATH-1:0][XLEN-1:0] prod_q;

  assign op[0] = a_i + b_i;
  assign op[1] = a_i - b_i;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    logic [XLEN-1:0] prod_d;
    // low XLEN bits of the signed product do not depend on signedness
    assign prod_d = op[g] * c_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   prod_q[g] <= '0;
      else if (ld_i) prod_q[g] <= prod_d;
    end
  end

  assign p_sum_o = prod_q[0];
  assign p_dif_o = prod_q[1];

  AST_ZERO_COEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && c_i == '0) |=> (p_sum_o == '0 && p_dif_o == '0)); // R3
endmodule

// File: rtl/bfly_rnd_shift.sv
module bfly_rnd_shift #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SHW  = 5
) (
  input  logic [XLEN-1:0] x_i,
  input  logic [SHW-1:0]  n_i,
  output logic [XLEN-1:0] y_o
);
  localparam int unsigned WW = XLEN + 1;

  logic signed [WW-1:0] ext;
  logic signed [WW-1:0] rc;
  logic signed [WW-1:0] acc;
  logic signed [WW-1:0] shf;

  always_comb begin
    ext = $signed({x_i[XLEN-1], x_i});
    rc  = '0;
    if (n_i != '0) rc = $signed(WW'(1) << (n_i - SHW'(1)));
    acc = ext + rc;
    shf = acc >>> n_i;
    y_o = shf[XLEN-1:0];
  end

  always_comb begin
    if (n_i == '0) AST_PASS_N0: assert (y_o == x_i); // R5
  end
endmodule

// File: rtl/bfly_pipe_ctl.sv
module bfly_pipe_ctl
  import bfly_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic           rsv_i,
  input  logic [SHW-1:0] n_i,
  input  logic           rsp_ready_i,
  output logic           req_ready_o,
  output logic           adv_o,
  output stage_ctl_t     s1_o,
  output stage_ctl_t     s2_o
);
  stage_ctl_t s1_q, s2_q;

  assign adv_o       = !s2_q.vld || rsp_ready_i;
  assign req_ready_o = adv_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (adv_o) begin
      s1_q.vld <= req_valid_i;
      if (req_valid_i) begin
        s1_q.ill <= rsv_i;
        s1_q.sh  <= n_i;
      end
      s2_q.vld <= s1_q.vld;
      if (s1_q.vld) begin
        s2_q.ill <= s1_q.ill;
        s2_q.sh  <= s1_q.sh;
      end
    end
  end

  assign s1_o = s1_q;
  assign s2_o = s2_q;

  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_q.vld && !rsp_ready_i) |-> !req_ready_o); // R9
  AST_ACCEPT_S1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> s1_q.vld); // R7
  AST_FLOW_S2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_q.vld && adv_o) |=> s2_q.vld); // R7
endmodule

// File: rtl/twin_bfly_rnd.sv
module twin_bfly_rnd
  import bfly_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] c_i,
  input  logic [SHW-1:0]  n_i,
  input  logic            rsv_i,
  output logic            rsp_valid_o,
  input  logic            rsp_ready_i,
  output logic [XLEN-1:0] res_sum_o,
  output logic [XLEN-1:0] res_dif_o,
  output logic            illegal_o
);
  logic            adv;
  stage_ctl_t      s1, s2;
  logic [XLEN-1:0] p_sum, p_dif;
  logic [XLEN-1:0] r_sum, r_dif;
  logic [XLEN-1:0] sum_q, dif_q;

  bfly_pipe_ctl i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .rsv_i       (rsv_i),
    .n_i         (n_i),
    .rsp_ready_i (rsp_ready_i),
    .req_ready_o (req_ready_o),
    .adv_o       (adv),
    .s1_o        (s1),
    .s2_o        (s2)
  );

  bfly_prod_stage #(.XLEN(XLEN)) i_prod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (adv && req_valid_i && !rsv_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .p_sum_o (p_sum),
    .p_dif_o (p_dif)
  );

  bfly_rnd_shift #(.XLEN(XLEN), .SHW(SHW)) i_rnd_sum (
    .x_i (p_sum),
    .n_i (s1.sh),
    .y_o (r_sum)
  );

  bfly_rnd_shift #(.XLEN(XLEN), .SHW(SHW)) i_rnd_dif (
    .x_i (p_dif),
    .n_i (s1.sh),
    .y_o (r_dif)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      dif_q <= '0;
    end else if (adv && s1.vld && !s1.ill) begin
      sum_q <= r_sum;
      dif_q <= r_dif;
    end
  end

  assign rsp_valid_o = s2.vld;
  assign illegal_o   = s2.ill;
  assign res_sum_o   = sum_q;
  assign res_dif_o   = dif_q;

  AST_ILL_KEEPS_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && s1.vld && s1.ill) |=> ($stable(res_sum_o) && $stable(res_dif_o))); // R8
  AST_ILL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && s1.vld) |=> (illegal_o == $past(s1.ill))); // R8
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(res_sum_o)
      && $stable(res_dif_o) && $stable(illegal_o))); // R9
endmodule

// File: tb/test_twin_bfly_rnd.sv
`timescale 1ns/1ps
module test_twin_bfly_rnd;
  localparam int XL = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0, rsv = 1'b0;
  logic [XL-1:0] a = '0, b = '0, c = '0;
  logic [4:0] n = '0;
  logic req_ready, rsp_valid, illegal;
  logic [XL-1:0] res_sum, res_dif;

  always #2 clk = ~clk;

  twin_bfly_rnd #(.XLEN(XL)) i_twin_bfly_rnd (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .a_i(a), .b_i(b), .c_i(c), .n_i(n), .rsv_i(rsv),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .res_sum_o(res_sum), .res_dif_o(res_dif), .illegal_o(illegal)
  );

  int total = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [XL-1:0] q_sum[$], q_dif[$];
  bit q_ill[$], q_lat[$];
  int q_acc[$];
  string q_tag[$];
  logic [XL-1:0] last_sum = '0, last_dif = '0;
  bit stall_prev = 0;
  logic [XL-1:0] hold_sum, hold_dif;
  bit hold_ill;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [XL-1:0] ref_rnd(logic [XL-1:0] p, int sh);
    logic signed [XL:0] w;
    logic signed [XL:0] s;
    w = $signed({p[XL-1], p});
    if (sh > 0) w = w + ((XL+1)'(1) << (sh - 1));
    s = w >>> sh;
    return s[XL-1:0];
  endfunction

  task automatic chk(bit ok, string tag, logic [XL-1:0] act, logic [XL-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [XL-1:0] ta, logic [XL-1:0] tb_, logic [XL-1:0] tc,
                      int tn, bit tr, bit rdy, string tag, bit lat, bit tput);
    @(negedge clk);
    req_valid = v; a = ta; b = tb_; c = tc; n = 5'(tn); rsv = tr; rsp_ready = rdy;
    #1;
    if (stall_prev) begin
      chk(rsp_valid && res_sum == hold_sum && res_dif == hold_dif && illegal == hold_ill,
          "R9 hold", res_sum, hold_sum);
    end
    stall_prev = rsp_valid && !rsp_ready;
    hold_sum = res_sum; hold_dif = res_dif; hold_ill = illegal;
    if (tput) chk(req_ready == 1'b1, "R11 ready", {63'd0, req_ready}, 64'd1);
    if (rsp_valid && rsp_ready) begin
      if (q_sum.size() == 0) chk(0, "R7 spurious response", 64'd1, 64'd0);
      else begin
        logic [XL-1:0] es, ed; bit ei, el; int ac; string t;
        es = q_sum.pop_front(); ed = q_dif.pop_front(); ei = q_ill.pop_front();
        el = q_lat.pop_front(); ac = q_acc.pop_front(); t = q_tag.pop_front();
        chk(res_sum == es, {t, " R1 sum"}, res_sum, es);
        chk(res_dif == ed, {t, " R2 dif"}, res_dif, ed);
        chk(illegal == ei, {t, " R8 illegal"}, {63'd0, illegal}, {63'd0, ei});
        if (el) chk(cyc - ac == 2, {t, " R7 latency"}, 64'(cyc - ac), 64'd2);
      end
    end
    if (v && req_ready) begin
      if (tr) begin
        q_sum.push_back(last_sum); q_dif.push_back(last_dif); q_ill.push_back(1);
      end else begin
        last_sum = ref_rnd((ta + tb_) * tc, tn);
        last_dif = ref_rnd((ta - tb_) * tc, tn);
        q_sum.push_back(last_sum); q_dif.push_back(last_dif); q_ill.push_back(0);
      end
      q_lat.push_back(lat); q_acc.push_back(cyc); q_tag.push_back(tag);
    end
  endtask

  task automatic send(logic [XL-1:0] ta, logic [XL-1:0] tb_, logic [XL-1:0] tc,
                      int tn, bit tr, string tag);
    step(1, ta, tb_, tc, tn, tr, 1, tag, 1, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(0, '0, '0, '0, 0, 0, 1, "drain", 0, 0);
  endtask

  localparam logic [XL-1:0] MINV = {1'b1, {(XL-1){1'b0}}};
  localparam logic [XL-1:0] MAXV = {1'b0, {(XL-1){1'b1}}};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(rsp_valid == 0 && illegal == 0, "R10 flags", {62'd0, rsp_valid, illegal}, 64'd0);
    chk(res_sum == 0 && res_dif == 0, "R10 results", res_sum | res_dif, 64'd0);
    rst_n = 1'b1;
    send(64'd5, 64'd3, 64'd2, 1, 0, "R1 R2 basic");           // 8,2
    send(64'd1, 64'd2, 64'd1, 1, 0, "R4 half");               // sum 2, dif 0
    send(64'd2, 64'd1, 64'd1, 1, 0, "R4 half pos");           // 2, 1
    send(-64'sd3, 64'd0, 64'd1, 1, 0, "R4 neg half");         // -1, -1
    send(MAXV, 64'd0, 64'd1, 1, 0, "R4 max no overflow");     // 2^62
    send(64'd7, -64'sd9, 64'd3, 0, 0, "R5 n0");               // -6, 48
    send(MINV, 64'd1, 64'd1, 0, 0, "R5 n0 min");
    send(MINV, MINV, 64'd5, 3, 0, "R3 min min");
    send(MINV, 64'd1, MINV, 0, 0, "R3 min coef");
    send(64'd12345, -64'sd777, 64'd0, 14, 0, "R3 c0");
    send(64'h0123_4567_89ab_cdef, 64'h1111, 64'd11585, 14, 0, "R1 dct14");
    send(MAXV, MINV, 64'd3, 31, 0, "R6 n31");
    send(64'd9, 64'd4, 64'd7, 2, 1, "R8 reserved");
    send(64'd9, 64'd4, 64'd7, 2, 1, "R8 reserved twice");
    send(64'd9, 64'd4, 64'd7, 2, 0, "R8 legal after");
    drain();
    // R11 throughput with random data
    for (int i = 0; i < 200; i++)
      step(1, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
           int'($urandom_range(0, 31)), ($urandom_range(0, 9) == 0), 1, "R11 stream", 1, 1);
    drain();
    // R9 random backpressure and bubbles
    for (int i = 0; i < 2000; i++) begin
      logic [XL-1:0] ra, rb, rc;
      int k;
      k = int'($urandom_range(0, 5));
      ra = (k == 0) ? MINV : (k == 1) ? MAXV : {$urandom, $urandom};
      rb = (k == 2) ? MINV : {$urandom, $urandom};
      rc = (k == 3) ? '0 : (k == 4) ? 64'(-1) : {$urandom, $urandom};
      step($urandom_range(0, 3) != 0, ra, rb, rc, int'($urandom_range(0, 31)),
           ($urandom_range(0, 7) == 0), $urandom_range(0, 2) != 0, "R9 random", 0, 0);
    end
    drain();
    chk(q_sum.size() == 0, "R7 all responses returned", 64'(q_sum.size()), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog R7 act=%0d exp=0", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule